// File: doc/BRIEF.md
# Privileged Trap Controller

This block steers the program counter whenever a fault, an interrupt or a privileged call arrives, and when a privileged handler returns. A nonzero event code on a cycle causes a redirect to the handler whose address is the privileged base register plus a fixed per-event offset. The redirect appears on the outputs in the following cycle. Bit 0 of the current PC marks privileged execution. Every offset also carries bit 0 set, so each handler runs in privileged mode.

The block holds the exception address register, which is the resume point for a return. It also holds a single shadow-bank flag. While the flag is set, a fixed group of integer register indices is steered to an alternate bank. The flag is swapped in on entry from non-privileged code. It is swapped out on a return whose target has bit 0 clear, and that return also asks the core to re-examine pending interrupts. Asking for a swap into the bank state that is already active is reported as an error, and the flag is left as it was.

Top module: `priv_trap_unit`

## Requirements
- R1: During reset the shadow flag reads 1 and no redirect is shown. In the first cycle after reset is released, a redirect is shown with new PC equal to base + 0x0001 and next PC equal to base + 0x0005.
- R2: Event code encoding and handler offsets (code 0 means no event). Code 1 is reset (0x0001), code 2 is machine check (0x0401), and code 3 is arithmetic or integer overflow (0x0501). Code 4 is interrupt (0x0101), code 5 is native data TLB miss (0x0201), and code 6 is privileged data TLB miss (0x0281). Code 7 is alignment (0x0301), codes 8 and 9 are data TLB fault and data access violation (0x0381), and codes 10 and 11 are instruction TLB miss and fault (0x0181). Code 12 is instruction access violation (0x0081), code 13 is unimplemented opcode (0x0481), code 14 is FP disabled (0x0581), and code 15 is privileged call (0x2001).
- R3: One cycle after a nonzero event code, the redirect output pulses. New PC is then base + offset, and next PC is new PC + 4.
- R4: On an event, the exception address captures the current PC. The one exception is an interrupt (code 4) taken while cur_pc bit 0 is 1, which leaves the register unchanged.
- R5: For a privileged call (code 15), the captured exception address is the current PC + 4.
- R6: An event taken with cur_pc bit 0 clear sets the shadow flag. An event taken with bit 0 set leaves the flag alone.
- R7: While the shadow flag is 1, the alternate-bank output is 1 exactly for register indices 8 through 14 and 25. While the flag is 0, that output is 0.
- R8: A return request with cur_pc bit 0 clear pulses the return-fault output one cycle later, with no return and no change to the shadow flag.
- R9: A return request with cur_pc bit 0 set pulses the return output one cycle later, with next PC equal to the exception address held before the request.
- R10: A return whose exception address has bit 0 clear clears the shadow flag and pulses the interrupt-recheck output. With bit 0 set, the return does neither.
- R11: A software write to the exception address stores the written value with bit 1 forced to 0.
- R12: A swap into the active bank state raises the swap-error output for one cycle and leaves the flag unchanged. This covers a non-privileged event while the flag is 1, and a bit-0-clear return while the flag is 0.
- R13: Priority within a cycle runs from event, to return request, to software write. An input of lower priority that arrives with one of higher priority is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_code | input | 4 | Event code, 0 = none (R2) |
| cur_pc | input | AW | Current PC, bit 0 = privileged |
| pal_base | input | AW | Privileged handler base address |
| ret_req | input | 1 | Return-from-handler request |
| ea_wr_en | input | 1 | Software write to exception address |
| ea_wr_data | input | AW | Data for the software write |
| reg_idx | input | RW | Integer register index to steer |
| redir_o | output | 1 | Trap redirect pulse |
| new_pc_o | output | AW | Redirect PC |
| next_pc_o | output | AW | Next PC (redirect or return) |
| ret_o | output | 1 | Return pulse |
| exc_addr_o | output | AW | Exception address register |
| shadow_o | output | 1 | Shadow bank flag |
| reg_alt_o | output | 1 | reg_idx maps to the alternate bank |
| ret_fault_o | output | 1 | Illegal return pulse |
| swap_err_o | output | 1 | Redundant swap pulse |
| irq_recheck_o | output | 1 | Pending interrupt recheck pulse |

## Verification
The assertions assume that bit 0 of cur_pc reflects the real privilege state. They also assume that pal_base has bit 0 clear and that it stays constant while the block runs, since the next-PC and return checks compare against earlier sampled values. The stimulus uses one even base address for the whole run. It changes inputs only on the falling clock edge, and it applies mixed requests only in the scenario written to test priority.

// File: rtl/priv_trap_unit.sv
module priv_trap_unit #(
  parameter int AW = 64,
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    ev_code,
  input  logic [AW-1:0] cur_pc,
  input  logic [AW-1:0] pal_base,
  input  logic          ret_req,
  input  logic          ea_wr_en,
  input  logic [AW-1:0] ea_wr_data,
  input  logic [RW-1:0] reg_idx,
  output logic          redir_o,
  output logic [AW-1:0] new_pc_o,
  output logic [AW-1:0] next_pc_o,
  output logic          ret_o,
  output logic [AW-1:0] exc_addr_o,
  output logic          shadow_o,
  output logic          reg_alt_o,
  output logic          ret_fault_o,
  output logic          swap_err_o,
  output logic          irq_recheck_o
);
  localparam logic [3:0] EV_INTR = 4'd4;
  localparam logic [3:0] EV_CALL = 4'd15;

  function automatic logic [15:0] vec_off(input logic [3:0] c);
    case (c)
      4'd1:        vec_off = 16'h0001;
      4'd2:        vec_off = 16'h0401;
      4'd3:        vec_off = 16'h0501;
      4'd4:        vec_off = 16'h0101;
      4'd5:        vec_off = 16'h0201;
      4'd6:        vec_off = 16'h0281;
      4'd7:        vec_off = 16'h0301;
      4'd8, 4'd9:  vec_off = 16'h0381;
      4'd10, 4'd11: vec_off = 16'h0181;
      4'd12:       vec_off = 16'h0081;
      4'd13:       vec_off = 16'h0481;
      4'd14:       vec_off = 16'h0581;
      4'd15:       vec_off = 16'h2001;
      default:     vec_off = 16'h0000;
    endcase
  endfunction

  logic          boot_q;
  logic          priv;
  logic [AW-1:0] tgt;

  assign priv = cur_pc[0];
  assign tgt  = pal_base + {{(AW-16){1'b0}}, vec_off(ev_code)};
  assign reg_alt_o = shadow_o &&
                     (((reg_idx >= RW'(8)) && (reg_idx <= RW'(14))) || (reg_idx == RW'(25)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q        <= 1'b1;
      shadow_o      <= 1'b1;
      exc_addr_o    <= '0;
      new_pc_o      <= '0;
      next_pc_o     <= '0;
      redir_o       <= 1'b0;
      ret_o         <= 1'b0;
      ret_fault_o   <= 1'b0;
      swap_err_o    <= 1'b0;
      irq_recheck_o <= 1'b0;
    end else begin
      redir_o       <= 1'b0;
      ret_o         <= 1'b0;
      ret_fault_o   <= 1'b0;
      swap_err_o    <= 1'b0;
      irq_recheck_o <= 1'b0;
      if (boot_q) begin
        boot_q    <= 1'b0;
        redir_o   <= 1'b1;
        new_pc_o  <= pal_base + AW'(1);
        next_pc_o <= pal_base + AW'(5);
      end else if (ev_code != 4'd0) begin
        redir_o   <= 1'b1;
        new_pc_o  <= tgt;
        next_pc_o <= tgt + AW'(4);
        if (!(ev_code == EV_INTR && priv))
          exc_addr_o <= cur_pc + ((ev_code == EV_CALL) ? AW'(4) : AW'(0));
        if (!priv) begin
          if (shadow_o) swap_err_o <= 1'b1;
          else          shadow_o   <= 1'b1;
        end
      end else if (ret_req) begin
        if (!priv) begin
          ret_fault_o <= 1'b1;
        end else begin
          ret_o     <= 1'b1;
          next_pc_o <= exc_addr_o;
          if (!exc_addr_o[0]) begin
            irq_recheck_o <= 1'b1;
            if (!shadow_o) swap_err_o <= 1'b1;
            else           shadow_o   <= 1'b0;
          end
        end
      end else if (ea_wr_en) begin
        exc_addr_o <= ea_wr_data & ~AW'(2);
      end
    end
  end
endmodule

// File: rtl/priv_trap_unit_chk.sv
module priv_trap_unit_chk #(
  parameter int AW = 64,
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic [3:0]    ev_code,
  input logic [AW-1:0] cur_pc,
  input logic          ret_req,
  input logic          ea_wr_en,
  input logic          redir_o,
  input logic [AW-1:0] new_pc_o,
  input logic [AW-1:0] next_pc_o,
  input logic          ret_o,
  input logic [AW-1:0] exc_addr_o,
  input logic          shadow_o,
  input logic          reg_alt_o,
  input logic          ret_fault_o,
  input logic          swap_err_o
);
  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n;

  a_r3_next_follows_new: assert property (@(posedge clk) disable iff (!rst_n)
    redir_o |-> next_pc_o == new_pc_o + AW'(4));

  a_r4_priv_intr_keeps_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && ev_code == 4'd4 && cur_pc[0]) |=> $stable(exc_addr_o));

  a_r5_call_skips_insn: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && ev_code == 4'd15) |=> exc_addr_o == $past(cur_pc) + AW'(4));

  a_r7_alt_needs_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    reg_alt_o |-> shadow_o);

  a_r8_user_return_faults: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && ev_code == 4'd0 && ret_req && !cur_pc[0]) |=> (ret_fault_o && !ret_o && $stable(shadow_o)));

  a_r11_wr_clears_bit1: assert property (@(posedge clk) disable iff (!rst_n)
    (up_q && ev_code == 4'd0 && !ret_req && ea_wr_en) |=> !exc_addr_o[1]);

  a_r12_err_no_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    swap_err_o |-> $stable(shadow_o));

  a_r13_one_action: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({redir_o, ret_o, ret_fault_o}));
endmodule

bind priv_trap_unit priv_trap_unit_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_code(ev_code), .cur_pc(cur_pc),
  .ret_req(ret_req), .ea_wr_en(ea_wr_en), .redir_o(redir_o),
  .new_pc_o(new_pc_o), .next_pc_o(next_pc_o), .ret_o(ret_o),
  .exc_addr_o(exc_addr_o), .shadow_o(shadow_o), .reg_alt_o(reg_alt_o),
  .ret_fault_o(ret_fault_o), .swap_err_o(swap_err_o));

// File: tb/priv_trap_unit_bench.sv
`timescale 1ns/1ps
module priv_trap_unit_bench;
  localparam logic [63:0] BASE = 64'h10000;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  ev_code = 0;
  logic [63:0] cur_pc = 0, pal_base = BASE, ea_wr_data = 0;
  logic        ret_req = 0, ea_wr_en = 0;
  logic [4:0]  reg_idx = 0;
  logic        redir_o, ret_o, shadow_o, reg_alt_o, ret_fault_o, swap_err_o, irq_recheck_o;
  logic [63:0] new_pc_o, next_pc_o, exc_addr_o;
  int errs = 0, checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  priv_trap_unit u_priv_trap_unit (
    .clk(clk), .rst_n(rst_n), .ev_code(ev_code), .cur_pc(cur_pc), .pal_base(pal_base),
    .ret_req(ret_req), .ea_wr_en(ea_wr_en), .ea_wr_data(ea_wr_data), .reg_idx(reg_idx),
    .redir_o(redir_o), .new_pc_o(new_pc_o), .next_pc_o(next_pc_o), .ret_o(ret_o),
    .exc_addr_o(exc_addr_o), .shadow_o(shadow_o), .reg_alt_o(reg_alt_o),
    .ret_fault_o(ret_fault_o), .swap_err_o(swap_err_o), .irq_recheck_o(irq_recheck_o));

  function automatic logic [63:0] off(input int c);
    case (c)
      1: off = 'h1;    2: off = 'h401;  3: off = 'h501;  4: off = 'h101;
      5: off = 'h201;  6: off = 'h281;  7: off = 'h301;  8: off = 'h381;
      9: off = 'h381;  10: off = 'h181; 11: off = 'h181; 12: off = 'h81;
      13: off = 'h481; 14: off = 'h581; 15: off = 'h2001; default: off = 0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [3:0] c, input logic [63:0] pc, input logic r,
                      input logic w, input logic [63:0] wd);
    @(negedge clk);
    ev_code = c; cur_pc = pc; ret_req = r; ea_wr_en = w; ea_wr_data = wd;
    @(posedge clk); #1;
  endtask

  task automatic t_reset();
    repeat (2) @(posedge clk); #1;
    chk("R1 shadow in reset", shadow_o, 1);
    chk("R1 no redirect in reset", redir_o, 0);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    chk("R1 boot redirect", redir_o, 1);
    chk("R1 boot pc", new_pc_o, BASE + 1);
    chk("R1 boot next", next_pc_o, BASE + 5);
  endtask

  task automatic t_leave_boot();
    step(0, BASE + 'h101, 1, 0, 0);
    chk("R9 return pulse", ret_o, 1);
    chk("R9 return target", next_pc_o, 0);
    chk("R10 bank out", shadow_o, 0);
    chk("R10 recheck", irq_recheck_o, 1);
    chk("R12 no error", swap_err_o, 0);
  endtask

  task automatic t_user_fault();
    step(7, 64'h4000, 0, 0, 0);
    chk("R3 redirect", redir_o, 1);
    chk("R3 new pc", new_pc_o, BASE + 'h301);
    chk("R3 next pc", next_pc_o, BASE + 'h305);
    chk("R4 capture", exc_addr_o, 64'h4000);
    chk("R6 bank in", shadow_o, 1);
    chk("R12 no error", swap_err_o, 0);
  endtask

  task automatic t_remap();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); reg_idx = 5'(i); #1;
      chk("R7 remap shadow on", reg_alt_o, ((i >= 8 && i <= 14) || i == 25) ? 1 : 0);
    end
  endtask

  task automatic t_priv_intr();
    step(4, BASE + 'h301, 0, 0, 0);
    chk("R4 priv intr keeps addr", exc_addr_o, 64'h4000);
    chk("R2 intr vector", new_pc_o, BASE + 'h101);
    chk("R6 priv no swap", shadow_o, 1);
    chk("R12 priv no error", swap_err_o, 0);
    step(2, BASE + 'h401, 0, 0, 0);
    chk("R4 priv mcheck captures", exc_addr_o, BASE + 'h401);
  endtask

  task automatic t_sw_write_and_return();
    step(0, BASE + 'h401, 0, 1, 64'h5007);
    chk("R11 bit1 cleared", exc_addr_o, 64'h5005);
    step(0, BASE + 'h401, 1, 0, 0);
    chk("R9 return pulse", ret_o, 1);
    chk("R9 return target", next_pc_o, 64'h5005);
    chk("R10 odd target keeps bank", shadow_o, 1);
    chk("R10 odd target no recheck", irq_recheck_o, 0);
  endtask

  task automatic t_user_return();
    step(0, 64'h6000, 1, 0, 0);
    chk("R8 fault", ret_fault_o, 1);
    chk("R8 no return", ret_o, 0);
    chk("R8 bank kept", shadow_o, 1);
  endtask

  task automatic t_call_redundant();
    step(15, 64'h7000, 0, 0, 0);
    chk("R5 skip", exc_addr_o, 64'h7004);
    chk("R2 call vector", new_pc_o, BASE + 'h2001);
    chk("R12 swap error", swap_err_o, 1);
    chk("R12 bank kept", shadow_o, 1);
    step(0, BASE + 1, 0, 1, 64'h8000);
    step(0, BASE + 1, 1, 0, 0);
    chk("R10 bank out", shadow_o, 0);
    step(0, BASE + 1, 1, 0, 0);
    chk("R12 return swap error", swap_err_o, 1);
    chk("R12 bank stays out", shadow_o, 0);
    @(negedge clk); reg_idx = 9; #1;
    chk("R7 no remap shadow off", reg_alt_o, 0);
  endtask

  task automatic t_priority();
    step(13, 64'h9001, 1, 1, 64'hAAAA);
    chk("R13 trap wins", redir_o, 1);
    chk("R13 no return", ret_o, 0);
    chk("R13 trap capture wins", exc_addr_o, 64'h9001);
    chk("R13 vector", new_pc_o, BASE + 'h481);
    step(0, 64'h9001, 1, 1, 64'hBBB8);
    chk("R13 return wins", ret_o, 1);
    chk("R13 write dropped", exc_addr_o, 64'h9001);
    step(4, 64'hA000, 0, 0, 0);
    chk("R4 user intr capture", exc_addr_o, 64'hA000);
    chk("R6 bank in", shadow_o, 1);
    step(0, 64'hA000, 0, 0, 0);
    chk("R3 idle no redirect", redir_o, 0);
  endtask

  task automatic t_sweep();
    for (int c = 1; c < 16; c++) begin
      step(4'(c), 64'h11, 0, 0, 0);
      chk($sformatf("R2 code %0d", c), new_pc_o, BASE + off(c));
      chk($sformatf("R3 next code %0d", c), next_pc_o, BASE + off(c) + 4);
    end
  endtask

  initial begin
    t_reset();
    t_leave_boot();
    t_user_fault();
    t_remap();
    t_priv_intr();
    t_sw_write_and_return();
    t_user_return();
    t_call_redundant();
    t_priority();
    t_sweep();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    #4000000;
    if (!done) begin
      done = 1;
      errs++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule